// File: doc/BRIEF.md
# Barrett Modular Reduction Unit

This unit reduces a 2N-bit unsigned operand modulo an N-bit modulus with Barrett's method and returns the residue in centered form, as a signed value between about -q/2 and +q/2. The host first loads the modulus together with its precomputed reciprocal, mu = floor(2^(2N) / q), through a plain configuration strobe. Operands then stream in through a valid/ready interface, and centered residues stream out through a second valid/ready interface.

The quotient is estimated in three steps. The operand is shifted right by N-1, the result is multiplied by mu, and that product is shifted right by N+1. The remainder is then formed from truncated low parts: the operand's low bits minus the low bits of (estimate × q). The estimate can fall short of the true quotient by up to two, so the truncated difference lies in [0, 3q). Two conditional subtractions bring it into [0, q). A final compare against q/2 maps it to the centered range.

The datapath is a three-stage pipeline that accepts one operand per cycle. Back-pressure works as follows. While `out_valid` is high and `out_ready` is low, the whole pipeline holds, `out_r` stays frozen and `in_ready` is low. No item is lost or duplicated, and results leave in the order their operands were accepted. The host reloads the configuration only while no operand is in flight.

Top module: `modred_barrett`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: A cycle with `cfg_load` high captures `cfg_q` and `cfg_mu`. Every operand accepted afterwards is reduced with that modulus. The modulus must satisfy 2^(N-1) < q < 2^N, and mu must equal floor(2^(2N)/q).
- R3: For operand c, let m = c mod q. Each result is m when 2m <= q, and m - q otherwise. It is presented on `out_r` as an (N+1)-bit two's-complement value.
- R4: The full operand range is reduced correctly, including c = 0 and c = 2^(2N) - 1.
- R5: With `out_ready` held high, an operand accepted at rising edge k has its result visible, with `out_valid` high, after rising edge k+2, and not before.
- R6: If `out_valid` is 1 and `out_ready` is 0, then in the next cycle `out_valid` is still 1 and `out_r` is unchanged.
- R7: `in_ready` is 0 only in a cycle where `out_valid` is 1 and `out_ready` is 0. Otherwise one operand is accepted every cycle.
- R8: Every accepted operand produces exactly one result, in acceptance order. At most three items are in flight.
- R9: When q is even, a residue of exactly q/2 is returned as +q/2, and a residue of q/2+1 is returned as -(q/2-1). A multiple of q returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Capture strobe for modulus and reciprocal |
| cfg_q | input | N | Modulus, 2^(N-1) < q < 2^N |
| cfg_mu | input | N+1 | Reciprocal floor(2^(2N)/q) |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_c | input | 2N | Operand to reduce |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_r | output | N+1 | Centered residue, two's complement |

## Verification
When the consumer never stalls, a result is due three rising edges after its operand is accepted: the acceptance edge and two more. Each stalled cycle pushes it back by one more edge. A dedicated latency check sends a single operand into an empty pipeline. It counts falling edges and expects `out_valid` to be low at the second falling edge after acceptance and high at the third. All other results are matched in order against a queue filled by the driver, and they are sampled on falling edges whenever a handshake is pending. This makes the checks independent of how the random back-pressure shifts each result's exact cycle.

// File: rtl/modred_pkg.sv
package modred_pkg;
  // number of register stages between operand acceptance and result
  localparam int unsigned PIPE_DEPTH = 3;
  // conditional subtractions needed after the truncated difference (< 3q)
  localparam int unsigned FOLD_STEPS = 2;
endpackage

// File: rtl/modred_quot.sv
module modred_quot #(
  parameter int unsigned N = 16
) (
  input  logic [2*N-1:0] c,
  input  logic [N:0]     mu,
  output logic [N:0]     qhat,
  output logic [N+1:0]   c_low
);
  localparam int unsigned PW = 2*N + 2;

  logic [N:0]    c_top;
  logic [PW-1:0] prod;
  logic          unused_prod_lo;

  assign c_top = c[2*N-1:N-1];
  assign prod  = {{(N+1){1'b0}}, c_top} * {{(N+1){1'b0}}, mu};
  assign qhat  = prod[PW-1:N+1];
  assign c_low = c[N+1:0];
  assign unused_prod_lo = ^prod[N:0];
endmodule

// File: rtl/modred_rem.sv
module modred_rem #(
  parameter int unsigned N = 16
) (
  input  logic [N:0]   qhat,
  input  logic [N+1:0] c_low,
  input  logic [N-1:0] q,
  output logic [N+1:0] rem
);
  localparam int unsigned PW = 2*N + 1;

  logic [PW-1:0] qq;
  logic          unused_qq_hi;

  assign qq  = {{N{1'b0}}, qhat} * {{(N+1){1'b0}}, q};
  assign rem = c_low - qq[N+1:0];
  assign unused_qq_hi = ^qq[PW-1:N+2];
endmodule

// File: rtl/modred_fold.sv
module modred_fold
  import modred_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic [N+1:0]        rem,
  input  logic [N-1:0]        q,
  output logic signed [N:0]   res
);
  localparam int unsigned W = N + 2;

  logic [W-1:0] chain [0:FOLD_STEPS];
  logic [W-1:0] q_w;
  logic [W:0]   twice;
  logic [N:0]   below;

  assign q_w      = {2'b00, q};
  assign chain[0] = rem;

  for (genvar i = 0; i < FOLD_STEPS; i++) begin : g_fold
    assign chain[i+1] = (chain[i] >= q_w) ? (chain[i] - q_w) : chain[i];
  end

  assign twice = {chain[FOLD_STEPS], 1'b0};
  assign below = chain[FOLD_STEPS][N:0] - {1'b0, q};

  always_comb begin
    if (twice > {2'b00, q_w[N-1:0], 1'b0} >> 1)
      res = $signed(below);
    else
      res = $signed(chain[FOLD_STEPS][N:0]);
  end
endmodule

// File: rtl/modred_barrett.sv
module modred_barrett #(
  parameter int unsigned N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  logic [N-1:0]         cfg_q,
  input  logic [N:0]           cfg_mu,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2*N-1:0]       in_c,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [N:0]    out_r
);
  localparam int unsigned RW = N + 2;

  logic [N-1:0] q_cfg;
  logic [N:0]   mu_cfg;

  logic            adv;
  logic [N:0]      qhat_c;
  logic [RW-1:0]   clow_c;
  logic            s1_v;
  logic [N:0]      s1_qhat;
  logic [RW-1:0]   s1_clow;
  logic [RW-1:0]   rem_c;
  logic            s2_v;
  logic [RW-1:0]   s2_rem;
  logic signed [N:0] res_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_cfg  <= '0;
      mu_cfg <= '0;
    end else if (cfg_load) begin
      q_cfg  <= cfg_q;
      mu_cfg <= cfg_mu;
    end
  end

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  modred_quot #(.N(N)) quot_i (
    .c     (in_c),
    .mu    (mu_cfg),
    .qhat  (qhat_c),
    .c_low (clow_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_qhat <= '0;
      s1_clow <= '0;
    end else if (adv) begin
      s1_v    <= in_valid;
      s1_qhat <= qhat_c;
      s1_clow <= clow_c;
    end
  end

  modred_rem #(.N(N)) rem_i (
    .qhat  (s1_qhat),
    .c_low (s1_clow),
    .q     (q_cfg),
    .rem   (rem_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v   <= 1'b0;
      s2_rem <= '0;
    end else if (adv) begin
      s2_v   <= s1_v;
      s2_rem <= rem_c;
    end
  end

  modred_fold #(.N(N)) fold_i (
    .rem (s2_rem),
    .q   (q_cfg),
    .res (res_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_r     <= '0;
    end else if (adv) begin
      out_valid <= s2_v;
      out_r     <= res_c;
    end
  end
endmodule

// File: rtl/modred_barrett_chk.sv
module modred_barrett_chk #(
  parameter int unsigned N = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic signed [N:0]   out_r,
  input logic [N-1:0]        q_cfg
);
  logic [31:0] n_acc;
  logic [31:0] n_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_acc  <= '0;
      n_done <= '0;
    end else begin
      if (in_valid && in_ready)   n_acc  <= n_acc + 1;
      if (out_valid && out_ready) n_done <= n_done + 1;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_r));

  p_centered_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed({out_r, 1'b0}) <= $signed({2'b00, q_cfg}))
              && ($signed({out_r, 1'b0}) > -$signed({2'b00, q_cfg})));

  p_stall_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready);

  p_no_extra_r8: assert property (@(posedge clk) disable iff (!rst_n)
    n_done <= n_acc);

  p_inflight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (n_acc - n_done) <= 32'd3);
endmodule

bind modred_barrett modred_barrett_chk #(.N(N)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_r     (out_r),
  .q_cfg     (q_cfg)
);

// File: tb/modred_barrett_tb_top.sv
`timescale 1ns/1ps
module modred_barrett_tb_top;
  localparam int N = 16;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                cfg_load = 1'b0;
  logic [N-1:0]        cfg_q = '0;
  logic [N:0]          cfg_mu = '0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [2*N-1:0]      in_c = '0;
  logic                out_valid;
  logic                out_ready = 1'b1;
  logic signed [N:0]   out_r;

  always #2 clk = ~clk;

  modred_barrett #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_q(cfg_q), .cfg_mu(cfg_mu),
    .in_valid(in_valid), .in_ready(in_ready), .in_c(in_c),
    .out_valid(out_valid), .out_ready(out_ready), .out_r(out_r)
  );

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  longint      cur_q = 0;
  bit          bp_en = 1'b0;
  bit          done = 1'b0;

  logic signed [N:0] exp_q [$];
  string             tag_q [$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint ref_center(input longint c, input longint q);
    longint m;
    m = c % q;
    if (2 * m > q) m = m - q;
    return m;
  endfunction

  task automatic load_cfg(input longint q);
    @(negedge clk);
    cfg_load = 1'b1;
    cfg_q    = N'(q);
    cfg_mu   = (N+1)'((64'd1 << (2*N)) / q);
    @(negedge clk);
    cfg_load = 1'b0;
    cur_q    = q;
  endtask

  task automatic send(input longint c, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_c     = (2*N)'(c);
    exp_q.push_back((N+1)'(ref_center(c, cur_q)));
    tag_q.push_back(tag);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #0.5;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(exp_q.size() == 0, "R8 drain", exp_q.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  // consumer back-pressure, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    out_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;
  end

  // monitor: scoreboard compare and stall behaviour
  bit                prev_stall = 1'b0;
  logic signed [N:0] prev_r = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        check(out_valid && out_r == prev_r, "R6 hold", out_r, prev_r);
      end
      if (!in_ready)
        check(out_valid && !out_ready, "R7 ready", in_ready, 1);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 extra result", out_r, 0);
        end else begin
          logic signed [N:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_r == e, t, out_r, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_r     = out_r;
    end
  end

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    longint q;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);

    load_cfg(65521);
    // R5 latency into an empty pipeline
    send(123456789, "R5 value");
    @(negedge clk);
    check(out_valid == 1'b0, "R5 early 1", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R5 early 2", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R5 due", out_valid, 1);
    drain();

    send(0, "R4 zero");
    send(64'hFFFF_FFFF, "R4 max");
    send(65521, "R9 q");
    send(65521 * 37, "R9 multiple");
    send(32760, "R3 below half");
    send(32761, "R3 above half");
    drain();

    load_cfg(32770);
    send(16385, "R2 new modulus");
    send(16385 + 32770 * 1000, "R9 half even");
    send(16386, "R9 half plus one");
    send(64'hFFFF_FFFF, "R4 max even q");
    drain();

    // back-to-back burst with no stall
    for (int i = 0; i < 8; i++) send(longint'($urandom), "R7 burst");
    drain();

    bp_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      q = (64'd1 << (N-1)) + 1 + ($urandom % ((1 << (N-1)) - 1));
      load_cfg(q);
      send(longint'($urandom), "R2 reload");
      for (int i = 0; i < 300; i++) begin
        if (($urandom % 4) == 0) @(negedge clk);
        send(longint'($urandom), "R3 random");
      end
      drain();
    end
    bp_en = 1'b0;
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done = 1'b1;
    $finish;
  end
endmodule